// File: doc/BRIEF.md
# Frame Reference and Host Presence Monitor

This block sits in the 48 MHz clock domain of a full-speed USB device core. It watches the strobe that the core raises when a start-of-frame packet arrives. From that strobe it produces two outputs for an external oscillator-trimming loop: a one-cycle reference pulse, and a level that says whether the pulse can be trusted as a 1 ms time base.

A watchdog counts microsecond ticks since the last frame. When the count reaches a configurable limit (4000 ticks, that is 4 ms, by default), it raises a host-lost level. The trust level is armed by a received frame. It is knocked down by an inactive link or a lost host, and it stays down until the next frame. The frame that arms the level is never itself flagged as trusted.

Top module: `sof_ref_monitor`

## Requirements
- R1: `refPulse` equals `sofStrobe` in the same cycle, with no register in between.
- R2: While `rstN` is low, and on the first cycles after release with no other stimulus, `refValid` and `hostLost` are 0.
- R3: `refValid` becomes 1 on the clock edge that samples `sofStrobe` high, so the output shows 1 from the following cycle on. During the strobe cycle itself it still shows its old value, which is 0 for the first frame.
- R4: If `sofStrobe` is low while `linkActive` is 0 or `hostLost` is 1, `refValid` is 0 after the next edge. It then stays 0 until a cycle with `sofStrobe` high.
- R5: When `sofStrobe` is high in the same cycle as a clearing condition of R4, `refValid` is 1 after the edge.
- R6: The presence count returns to zero on any edge where `sofStrobe` is high, `linkActive` is 0 or `busReset` is 1. A bench observes this as a full `LOST_US` ticks being needed again before `hostLost` rises.
- R7: The presence count advances by one only on edges where `usTick` is high and `hostLost` is 0, and it is held on every other edge.
- R8: `hostLost` is 1 exactly when the count has reached `LOST_US`. The count stops there without wrapping, so `hostLost` holds until a clearing condition of R6.
- R9: Pulling `rstN` low forces `refValid` and `hostLost` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz USB clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sofStrobe | input | 1 | One-cycle strobe: start-of-frame received |
| usTick | input | 1 | One-cycle strobe, once per microsecond |
| linkActive | input | 1 | Level: link is in the active state |
| busReset | input | 1 | Level: a bus reset is being signalled |
| refPulse | output | 1 | Frame reference pulse |
| refValid | output | 1 | Frame reference can be trusted |
| hostLost | output | 1 | No frame seen for `LOST_US` microseconds |

## Verification
The presence count is internal, so any fault in it shows only through the timing of `hostLost`. A count that clears too late, steps on the wrong edge or wraps moves the rise of `hostLost` off tick number `LOST_US`. It can also make `hostLost` fall again without a clearing event. Either effect appears one cycle after the offending tick, and then at `refValid` one cycle later. A wrong trust flag appears at `refValid` on the very next edge after a frame or a clearing condition. For that reason the bench sweeps the tick count across the whole window with a small limit and compares every cycle.

// File: rtl/sof_ref_pkg.sv
package sof_ref_pkg;

  // Strobes sent from the control to the presence counter each cycle
  typedef struct packed {
    logic clr;   // return the count to zero
    logic inc;   // advance the count by one
  } presCtl_t;

endpackage

// File: rtl/sof_ref_presence.sv
module sof_ref_presence
  import sof_ref_pkg::*;
#(
  parameter int LOST_US = 4000
) (
  input  logic     clk,
  input  logic     rstN,
  input  presCtl_t ctl,
  output logic     lost
);

  localparam int CNT_W = $clog2(LOST_US + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOST_US);

  logic [CNT_W-1:0] presCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presCnt <= '0;
    end else if (ctl.clr) begin
      presCnt <= '0;
    end else if (ctl.inc) begin
      presCnt <= presCnt + 1'b1;
    end
  end

  assign lost = (presCnt >= LIMIT);

  // R8: the count stops at the limit and never goes past it
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    presCnt <= LIMIT);

  // R6: a clear strobe leaves the count at zero after the edge
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clr |=> (presCnt == '0));

  // R7: the count moves only by one step or back to zero
  a_r7_step_only: assert property (@(posedge clk) disable iff (!rstN)
    (presCnt != $past(presCnt)) |-> ((presCnt == $past(presCnt) + 1'b1) || (presCnt == '0)));

  // R7: without an increment or clear strobe the count holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clr && !ctl.inc) |=> $stable(presCnt));

endmodule

// File: rtl/sof_ref_control.sv
module sof_ref_control
  import sof_ref_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sofStrobe,
  input  logic     usTick,
  input  logic     linkActive,
  input  logic     busReset,
  input  logic     lost,
  output presCtl_t ctl,
  output logic     valid
);

  logic validNext;

  always_comb begin
    ctl.clr = sofStrobe || !linkActive || busReset;
    ctl.inc = usTick && !lost;
  end

  // A frame sets the flag; otherwise a dead link or lost host clears it
  always_comb begin
    if (sofStrobe) begin
      validNext = 1'b1;
    end else if (!linkActive || lost) begin
      validNext = 1'b0;
    end else begin
      validNext = valid;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid <= 1'b0;
    end else begin
      valid <= validNext;
    end
  end

  // R3: the flag only rises after a frame strobe
  a_r3_rise_after_sof: assert property (@(posedge clk) disable iff (!rstN)
    $rose(valid) |-> $past(sofStrobe));

  // R5: a frame strobe always leaves the flag set
  a_r5_sof_wins: assert property (@(posedge clk) disable iff (!rstN)
    sofStrobe |=> valid);

  // R4: a clearing condition without a frame drops the flag
  a_r4_clear_drop: assert property (@(posedge clk) disable iff (!rstN)
    (!sofStrobe && (!linkActive || lost)) |=> !valid);

endmodule

// File: rtl/sof_ref_monitor.sv
module sof_ref_monitor
  import sof_ref_pkg::*;
#(
  parameter int LOST_US = 4000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sofStrobe,
  input  logic usTick,
  input  logic linkActive,
  input  logic busReset,
  output logic refPulse,
  output logic refValid,
  output logic hostLost
);

  presCtl_t presCtl;

  assign refPulse = sofStrobe;

  sof_ref_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sofStrobe  (sofStrobe),
    .usTick     (usTick),
    .linkActive (linkActive),
    .busReset   (busReset),
    .lost       (hostLost),
    .ctl        (presCtl),
    .valid      (refValid)
  );

  sof_ref_presence #(.LOST_US(LOST_US)) u_pres (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (presCtl),
    .lost (hostLost)
  );

  // R8: once lost, it stays lost until a clearing input is seen
  a_r8_lost_held: assert property (@(posedge clk) disable iff (!rstN)
    (hostLost && !sofStrobe && linkActive && !busReset) |=> hostLost);

endmodule

// File: tb/sim_sof_ref_monitor.sv
module sim_sof_ref_monitor;

  localparam int L = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sofStrobe = 1'b0, usTick = 1'b0, linkActive = 1'b1, busReset = 1'b0;
  logic refPulse, refValid, hostLost;

  int checks = 0;
  int failures = 0;
  int mCnt = 0;
  bit mValid = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sof_ref_monitor #(.LOST_US(L)) u0 (
    .clk(clk), .rstN(rstN), .sofStrobe(sofStrobe), .usTick(usTick),
    .linkActive(linkActive), .busReset(busReset),
    .refPulse(refPulse), .refValid(refValid), .hostLost(hostLost)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle of inputs, then check outputs after the edge against the model
  task automatic cyc(bit s, bit t, bit a, bit r);
    bit lostNow;
    sofStrobe = s; usTick = t; linkActive = a; busReset = r;
    #1;
    check("R1 pulse", refPulse, s);
    lostNow = (mCnt >= L);
    if (s || !a || r) mCnt = 0;
    else if (t && !lostNow) mCnt = mCnt + 1;
    if (s) mValid = 1'b1;
    else if (!a || lostNow) mValid = 1'b0;
    @(posedge clk); #2;
    check("R4/R5 valid", refValid, mValid);
    check("R6/R7/R8 lost", hostLost, mCnt >= L);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R2 reset state
    #1;
    check("R2 valid in reset", refValid, 1'b0);
    check("R2 lost in reset", hostLost, 1'b0);
    @(posedge clk); #2; rstN = 1'b1;
    cyc(0, 0, 1, 0);
    check("R2 valid after release", refValid, 1'b0);

    // R3 first frame: old value during strobe, set afterwards
    sofStrobe = 1'b1; #1;
    check("R3 valid low during first pulse", refValid, 1'b0);
    cyc(1, 0, 1, 0);
    check("R3 valid after first pulse", refValid, 1'b1);

    // R7 no ticks: many idle cycles never lose the host
    for (int i = 0; i < 3 * L; i++) cyc(0, 0, 1, 0);
    check("R7 no count without tick", hostLost, 1'b0);

    // R8 sweep every tick count to past the limit
    for (int k = 1; k <= L + 3; k++) begin
      cyc(0, 1, 1, 0);
      check("R8 lost at tick count", hostLost, k >= L);
      cyc(0, 0, 1, 0);
    end
    check("R4 valid dropped by host lost", refValid, 1'b0);

    // R4 stays low with no frame; R6 frame clears loss
    cyc(0, 0, 1, 0);
    check("R4 stays low", refValid, 1'b0);
    cyc(1, 0, 1, 0);
    check("R6 frame clears lost", hostLost, 1'b0);
    check("R3 rearmed", refValid, 1'b1);

    // R6 partial counts then each clearing source restarts the window
    for (int src = 0; src < 3; src++) begin
      for (int k = 0; k < L - 1; k++) cyc(0, 1, 1, 0);
      if (src == 0) cyc(1, 0, 1, 0);
      else if (src == 1) cyc(0, 0, 1, 1);
      else cyc(0, 0, 0, 0);
      for (int k = 0; k < L - 1; k++) cyc(0, 1, 1, 0);
      check("R6 window restarted", hostLost, 1'b0);
      cyc(0, 1, 1, 0);
      check("R6 full window reached", hostLost, 1'b1);
      cyc(1, 0, 1, 0);
    end

    // R4 link inactive drops valid; R5 frame with link inactive wins
    cyc(1, 0, 1, 0);
    cyc(0, 0, 0, 0);
    check("R4 link inactive clears", refValid, 1'b0);
    cyc(1, 0, 0, 0);
    check("R5 frame beats inactive link", refValid, 1'b1);
    cyc(0, 1, 0, 0);
    check("R4 inactive after frame", refValid, 0);

    // R5 frame in same cycle as host lost
    cyc(1, 0, 1, 0);
    for (int k = 0; k < L; k++) cyc(0, 1, 1, 0);
    check("R8 lost before tie", hostLost, 1'b1);
    cyc(1, 1, 1, 0);
    check("R5 frame beats host lost", refValid, 1'b1);

    // R9 asynchronous reset mid-run
    for (int k = 0; k < L; k++) cyc(0, 1, 1, 0);
    #3; rstN = 1'b0; #1;
    check("R9 async valid", refValid, 1'b0);
    check("R9 async lost", hostLost, 1'b0);
    mCnt = 0; mValid = 1'b0;
    @(posedge clk); #2; rstN = 1'b1;
    cyc(0, 1, 1, 0);
    check("R9 after reset", hostLost, 1'b0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule